// File: doc/BRIEF.md
# Chained DMA Transfer Sequencer

This block drives one DMA channel. A start pulse loads a descriptor given on the configuration inputs. The descriptor holds a next-descriptor pointer, a source address, a destination address and a 32-bit control word. The block then steps through the transfer as a series of transactions on a request interface. Each request uses a valid/ready handshake, and the block waits for one response per request. A response can carry an error flag. In copy mode a transaction is one read burst from the source followed by one write burst to the destination. In fill mode only the write is issued, and its data word is a constant pattern. Burst payload data in copy mode moves through a buffer outside this block. The sequencer supplies the addresses, the lengths and the fill pattern.

Each transaction that completes without error decrements the transaction count. The source and destination addresses either advance by the burst size in bytes or stay fixed. When the count reaches zero the descriptor is finished. If chaining is enabled and the pointer is not zero, the block reads four words of the next descriptor from memory and runs that descriptor. Otherwise it returns to idle with a done pulse. A descriptor can request an interrupt pulse when it finishes. An error response either repeats the failed request or halts the channel with a sticky error flag.

Control word layout:
- bits [11:0]: transaction count
- bits [13:12]: beat width code
- bits [19:14]: burst length
- bit 20: fixed source
- bit 21: fixed destination
- bit 22: fill enable
- bit 23: fill with ones
- bit 24: retry on error
- bit 25: chain enable
- bit 26: interrupt on finish

Top module: `dma_chain_seq`

## Requirements
- R1: A descriptor with a transaction count of zero issues no request. The channel returns to idle with one done pulse.
- R2: In copy mode, each transaction issues a read (req_write=0) at the source address, then a write (req_write=1) at the destination address, both with the burst length. After the count's worth of error-free transactions the channel goes idle and pulses done once.
- R3: Width code 0 gives 1 byte per beat, code 1 gives 2 bytes and code 2 gives 4 bytes. A non-fixed address advances by burst length times the beat size after each completed transaction.
- R4: Width code 3 is reserved. Loading it sets err_flag and returns to idle with no request and no done pulse.
- R5: When bit 20 is set, every read of the descriptor uses the same source address.
- R6: When bit 21 is set, every write of the descriptor uses the same destination address.
- R7: A burst field of 0 gives req_len 64. Any other value N gives req_len N. Descriptor fetch reads use req_len 1.
- R8: With bit 22 set, no data reads are issued. Each write carries all ones in req_wdata when bit 23 is set, and all zeros when bit 23 is clear.
- R9: With bit 24 set, an error response reissues the same request (same direction, address and length) and the transfer goes on.
- R10: With bit 24 clear, an error response halts the channel. busy drops, done does not pulse, and err_flag stays high until err_clr.
- R11: With bit 25 set and a non-zero pointer, the finished descriptor is followed by four single-beat reads at pointer, +4, +8 and +12. These return the next pointer, source, destination and control words in that order, and the new descriptor then runs. A zero pointer ends the chain.
- R12: A finished descriptor with bit 26 set produces exactly one single-cycle irq pulse.
- R13: While req_valid is high and req_ready is low, req_valid, req_write, req_addr and req_len hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the cfg_* descriptor while idle |
| err_clr | input | 1 | Clear the sticky error flag |
| cfg_next | input | AW | First descriptor: next pointer |
| cfg_src | input | AW | First descriptor: source address |
| cfg_dst | input | AW | First descriptor: destination address |
| cfg_ctrl | input | 32 | First descriptor: control word |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Request start address |
| req_len | output | BW+1 | Beats in request |
| req_wdata | output | DW | Fill pattern (zero in copy mode) |
| resp_valid | input | 1 | Response for the outstanding request |
| resp_err | input | 1 | Response reports an error |
| resp_rdata | input | DW | Read data (used for descriptor fetch) |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle pulse at chain end |
| irq | output | 1 | One-cycle pulse per flagged descriptor |
| err_flag | output | 1 | Sticky error |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data, and a 6-bit burst field, so req_len runs from 1 to 64. This makes the 64-beat case of the zero burst field reachable, along with all three legal beat sizes. The memory model stalls req_ready on alternate cycles in one scenario, which holds requests long enough to exercise the hold rule. It also injects an error on a chosen response, which reaches both the retry path and the halt path. A descriptor image placed at a small pointer address exercises chaining, including the zero-pointer end.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   localparam int CNT_W   = 12;
   localparam int BURST_W = 6;
   localparam int CTL_W   = 32;

   typedef struct packed {
      logic [4:0]         rsvd;
      logic               link_irq;
      logic               link_en;
      logic               retry;
      logic               fill_one;
      logic               fill_en;
      logic               dst_fix;
      logic               src_fix;
      logic [BURST_W-1:0] burst;
      logic [1:0]         wcode;
      logic [CNT_W-1:0]   count;
   } ctl_t;

   typedef enum logic [3:0] {
      ST_IDLE, ST_LOAD, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT,
      ST_FINISH, ST_FT_REQ, ST_FT_WAIT
   } seq_state_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int AW    = 32,
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    load_addr,
   input  logic             adv,
   input  logic             hold,
   input  logic [1:0]       wcode,
   input  logic [LEN_W-1:0] len,
   output logic [AW-1:0]    addr
);
   localparam int STEP_W = LEN_W + 2;

   logic [STEP_W-1:0] step;
   assign step = {2'b00, len} << wcode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               addr <= '0;
      else if (load)            addr <= load_addr;
      else if (adv && !hold)    addr <= addr + AW'(step);
   end
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          is_zero,
   output logic          is_last
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign is_zero = (cnt == '0);
   assign is_last = (cnt == CW'(1));
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dma_seq_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int BW = BURST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              err_clr,
   input  logic [AW-1:0]     cfg_next,
   input  logic [AW-1:0]     cfg_src,
   input  logic [AW-1:0]     cfg_dst,
   input  logic [CTL_W-1:0]  cfg_ctrl,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic [AW-1:0]     req_addr,
   output logic [BW:0]       req_len,
   output logic [DW-1:0]     req_wdata,
   input  logic              resp_valid,
   input  logic              resp_err,
   input  logic [DW-1:0]     resp_rdata,
   output logic              busy,
   output logic              done,
   output logic              irq,
   output logic              err_flag
);
   localparam int LEN_W      = BW + 1;
   localparam int MAX_BURST  = 1 << BW;
   localparam int WORD_BYTES = 4;
   localparam int N_PORTS    = 2;

   initial begin
      if (BW != BURST_W) $error("BW must match the control word burst field");
      if (AW < 16 || AW > DW) $error("AW must lie in 16..DW");
      if (DW < CTL_W) $error("DW must hold a control word");
   end

   seq_state_t state;
   ctl_t       ctl_q;
   logic [AW-1:0] next_q;
   logic [1:0]    fidx;
   logic [AW-1:0] fbuf [3];
   logic          done_q, irq_q, err_q;

   // load path: from cfg on start, or from fetched words
   logic          ld_en;
   logic [AW-1:0] ld_src, ld_dst, ld_next;
   ctl_t          ld_ctl;
   logic          fetch_last_ok;

   assign fetch_last_ok = (state == ST_FT_WAIT) && resp_valid && !resp_err && (fidx == 2'd3);

   always_comb begin
      ld_en   = 1'b0;
      ld_src  = cfg_src;
      ld_dst  = cfg_dst;
      ld_next = cfg_next;
      ld_ctl  = ctl_t'(cfg_ctrl);
      if (state == ST_IDLE && start) begin
         ld_en = 1'b1;
      end else if (fetch_last_ok) begin
         ld_en   = 1'b1;
         ld_next = fbuf[0];
         ld_src  = fbuf[1];
         ld_dst  = fbuf[2];
         ld_ctl  = ctl_t'(resp_rdata[CTL_W-1:0]);
      end
   end

   // burst length decode: zero field means the maximum
   logic [LEN_W-1:0] blen;
   assign blen = (ctl_q.burst == '0) ? LEN_W'(MAX_BURST) : {1'b0, ctl_q.burst};

   // one completed, error-free write
   logic xfer_ok;
   assign xfer_ok = (state == ST_WR_WAIT) && resp_valid && !resp_err;

   // address steppers: index 0 = source, 1 = destination
   logic [AW-1:0] addr_q  [N_PORTS];
   logic [AW-1:0] addr_ld [N_PORTS];
   logic          addr_fx [N_PORTS];

   assign addr_ld[0] = ld_src;
   assign addr_ld[1] = ld_dst;
   assign addr_fx[0] = ctl_q.src_fix;
   assign addr_fx[1] = ctl_q.dst_fix;

   generate
      for (genvar g = 0; g < N_PORTS; g++) begin : g_port
         dma_addr_step #(.AW(AW), .LEN_W(LEN_W)) i_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (ld_en),
            .load_addr (addr_ld[g]),
            .adv       (xfer_ok),
            .hold      (addr_fx[g]),
            .wcode     (ctl_q.wcode),
            .len       (blen),
            .addr      (addr_q[g])
         );
      end
   endgenerate

   logic cnt_zero, cnt_last;

   dma_xfer_cnt #(.CW(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_en),
      .load_val (ld_ctl.count),
      .dec      (xfer_ok),
      .is_zero  (cnt_zero),
      .is_last  (cnt_last)
   );

   // fill pattern: replicated select bit, or zero in copy mode
   logic [DW-1:0] fill_word;
   generate
      if (DW > 0) begin : g_fill
         assign fill_word = ctl_q.fill_en ? {DW{ctl_q.fill_one}} : '0;
      end
   endgenerate

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ctl_q  <= '0;
         next_q <= '0;
         fidx   <= '0;
         for (int i = 0; i < 3; i++) fbuf[i] <= '0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         if (err_clr) err_q <= 1'b0;
         if (ld_en) begin
            ctl_q  <= ld_ctl;
            next_q <= ld_next;
         end
         unique case (state)
            ST_IDLE:  if (start) state <= ST_LOAD;
            ST_LOAD: begin
               if (ctl_q.wcode == 2'b11) begin
                  err_q <= 1'b1;
                  state <= ST_IDLE;
               end else if (cnt_zero)   state <= ST_FINISH;
               else if (ctl_q.fill_en) state <= ST_WR_REQ;
               else                    state <= ST_RD_REQ;
            end
            ST_RD_REQ: if (req_ready) state <= ST_RD_WAIT;
            ST_RD_WAIT: if (resp_valid) begin
               if (!resp_err)          state <= ST_WR_REQ;
               else if (ctl_q.retry)   state <= ST_RD_REQ;
               else begin
                  err_q <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_WR_REQ: if (req_ready) state <= ST_WR_WAIT;
            ST_WR_WAIT: if (resp_valid) begin
               if (!resp_err) begin
                  if (cnt_last)           state <= ST_FINISH;
                  else if (ctl_q.fill_en) state <= ST_WR_REQ;
                  else                    state <= ST_RD_REQ;
               end else if (ctl_q.retry) state <= ST_WR_REQ;
               else begin
                  err_q <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_FINISH: begin
               irq_q <= ctl_q.link_irq;
               if (ctl_q.link_en && next_q != '0) begin
                  fidx  <= '0;
                  state <= ST_FT_REQ;
               end else begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            ST_FT_REQ: if (req_ready) state <= ST_FT_WAIT;
            ST_FT_WAIT: if (resp_valid) begin
               if (resp_err) begin
                  if (ctl_q.retry) state <= ST_FT_REQ;
                  else begin
                     err_q <= 1'b1;
                     state <= ST_IDLE;
                  end
               end else if (fidx == 2'd3) begin
                  state <= ST_LOAD;
               end else begin
                  fbuf[fidx] <= resp_rdata[AW-1:0];
                  fidx       <= fidx + 1'b1;
                  state      <= ST_FT_REQ;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // request outputs
   logic fetch_now, fill_now;
   assign fetch_now = (state == ST_FT_REQ);
   assign fill_now  = ctl_q.fill_en;

   always_comb begin
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr  = addr_q[0];
      req_len   = blen;
      req_wdata = '0;
      unique case (state)
         ST_RD_REQ: req_valid = 1'b1;
         ST_WR_REQ: begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = addr_q[1];
            req_wdata = fill_word;
         end
         ST_FT_REQ: begin
            req_valid = 1'b1;
            req_addr  = next_q + AW'(fidx) * AW'(WORD_BYTES);
            req_len   = LEN_W'(1);
         end
         default: ;
      endcase
   end

   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign irq      = irq_q;
   assign err_flag = err_q;
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
   parameter int AW    = 32,
   parameter int LEN_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             irq,
   input logic             err_flag,
   input logic             req_valid,
   input logic             req_ready,
   input logic             req_write,
   input logic [AW-1:0]    req_addr,
   input logic [LEN_W-1:0] req_len,
   input logic             fill_now,
   input logic             fetch_now
);
   localparam int MAXL = 1 << (LEN_W - 1);

   a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_write)
                                     && $stable(req_addr) && $stable(req_len)));

   a_r7_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != '0 && int'(req_len) <= MAXL));

   a_r7_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && fetch_now) |-> (req_len == LEN_W'(1) && !req_write));

   a_r8_fill_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && fill_now && !fetch_now) |-> req_write);

   a_r10_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> (!busy && !done));

   a_r12_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.AW(AW), .LEN_W(BW + 1)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .irq       (irq),
   .err_flag  (err_flag),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_len   (req_len),
   .fill_now  (fill_now),
   .fetch_now (fetch_now)
);

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 7;
   localparam int LOGN = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, err_clr = 1'b0;
   logic [AW-1:0] cfg_next = '0, cfg_src = '0, cfg_dst = '0;
   logic [31:0]   cfg_ctrl = '0;
   logic req_valid, req_write, req_ready;
   logic [AW-1:0] req_addr;
   logic [LW-1:0] req_len;
   logic [DW-1:0] req_wdata;
   logic resp_valid, resp_err;
   logic [DW-1:0] resp_rdata;
   logic busy, done, irq, err_flag;

   always #5 clk = ~clk;

   dma_chain_seq i_dma_chain_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .err_clr(err_clr),
      .cfg_next(cfg_next), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_ctrl(cfg_ctrl),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .busy(busy), .done(done), .irq(irq), .err_flag(err_flag)
   );

   // memory model and request log
   int nchk = 0, nfail = 0;
   int acc_n = 0, err_at = -1, done_n = 0, irq_n = 0;
   logic stall_en = 1'b0, rdy_t = 1'b1;
   logic [31:0] dmem [4];
   logic          lg_w    [LOGN];
   logic [AW-1:0] lg_addr [LOGN];
   logic [LW-1:0] lg_len  [LOGN];
   logic [DW-1:0] lg_wd   [LOGN];

   assign req_ready = stall_en ? rdy_t : 1'b1;

   always @(posedge clk) begin
      rdy_t      <= ~rdy_t;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      if (done) done_n <= done_n + 1;
      if (irq)  irq_n  <= irq_n + 1;
      if (rst_n && req_valid && req_ready) begin
         resp_valid <= 1'b1;
         resp_err   <= (acc_n == err_at);
         resp_rdata <= (req_addr[AW-1:4] == 28'h10) ? dmem[req_addr[3:2]] : 32'h5A5A_0000;
         if (acc_n < LOGN) begin
            lg_w[acc_n]    <= req_write;
            lg_addr[acc_n] <= req_addr;
            lg_len[acc_n]  <= req_len;
            lg_wd[acc_n]   <= req_wdata;
         end
         acc_n <= acc_n + 1;
      end
   end

   function automatic logic [31:0] mk_ctl(int cnt, int w, int bl, bit sfx, bit dfx,
                                          bit fil, bit one, bit rty, bit lnk, bit lirq);
      logic [31:0] c;
      c = '0;
      c[11:0] = 12'(cnt); c[13:12] = 2'(w); c[19:14] = 6'(bl);
      c[20] = sfx; c[21] = dfx; c[22] = fil; c[23] = one;
      c[24] = rty; c[25] = lnk; c[26] = lirq;
      return c;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_req(int i, bit w, logic [AW-1:0] a, int len, logic [DW-1:0] wd, string req);
      chk(lg_w[i] == w, req, $sformatf("req%0d dir", i), lg_w[i], w);
      chk(lg_addr[i] == a, req, $sformatf("req%0d addr", i), lg_addr[i], a);
      chk(int'(lg_len[i]) == len, req, $sformatf("req%0d len", i), lg_len[i], len);
      if (w) chk(lg_wd[i] == wd, req, $sformatf("req%0d wdata", i), lg_wd[i], wd);
   endtask

   task automatic run(logic [AW-1:0] nx, logic [AW-1:0] s, logic [AW-1:0] d, logic [31:0] c, int ea);
      @(negedge clk);
      acc_n = 0; done_n = 0; irq_n = 0; err_at = ea;
      cfg_next = nx; cfg_src = s; cfg_dst = d; cfg_ctrl = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!busy, "R2", "reset busy", busy, 0);
      chk(!err_flag, "R10", "reset err", err_flag, 0);
      chk(!req_valid, "R13", "reset valid", req_valid, 0);
      chk(!done && !irq, "R12", "reset pulses", {done, irq}, 0);
   endtask

   task automatic t_zero_count();
      run('0, 32'h1000, 32'h2000, mk_ctl(0, 2, 4, 0, 0, 0, 0, 0, 0, 0), -1);
      chk(acc_n == 0, "R1", "requests", acc_n, 0);
      chk(done_n == 1, "R1", "done pulses", done_n, 1);
   endtask

   task automatic t_copy_inc();
      stall_en = 1'b1;
      run('0, 32'h1000, 32'h2000, mk_ctl(2, 2, 4, 0, 0, 0, 0, 0, 0, 1), -1);
      stall_en = 1'b0;
      chk(acc_n == 4, "R2", "requests", acc_n, 4);
      chk_req(0, 0, 32'h1000, 4, 0, "R2");
      chk_req(1, 1, 32'h2000, 4, 0, "R2");
      chk_req(2, 0, 32'h1010, 4, 0, "R3");
      chk_req(3, 1, 32'h2010, 4, 0, "R3");
      chk(done_n == 1, "R2", "done pulses", done_n, 1);
      chk(irq_n == 1, "R12", "irq pulses", irq_n, 1);
      chk(!busy, "R2", "busy after", busy, 0);
   endtask

   task automatic t_fill();
      run('0, 32'h0, 32'h3000, mk_ctl(2, 0, 0, 0, 1, 1, 1, 0, 0, 0), -1);
      chk(acc_n == 2, "R8", "requests", acc_n, 2);
      chk_req(0, 1, 32'h3000, 64, 32'hFFFF_FFFF, "R7");
      chk_req(1, 1, 32'h3000, 64, 32'hFFFF_FFFF, "R6");
      chk(irq_n == 0, "R12", "irq pulses", irq_n, 0);
      run('0, 32'h0, 32'h4000, mk_ctl(2, 1, 5, 0, 0, 1, 0, 0, 0, 0), -1);
      chk(acc_n == 2, "R8", "requests", acc_n, 2);
      chk_req(0, 1, 32'h4000, 5, 32'h0, "R8");
      chk_req(1, 1, 32'h400A, 5, 32'h0, "R3");
   endtask

   task automatic t_src_fix();
      run('0, 32'h5000, 32'h6000, mk_ctl(2, 1, 3, 1, 0, 0, 0, 0, 0, 0), -1);
      chk(acc_n == 4, "R5", "requests", acc_n, 4);
      chk_req(2, 0, 32'h5000, 3, 0, "R5");
      chk_req(3, 1, 32'h6006, 3, 0, "R3");
   endtask

   task automatic t_err_halt();
      run('0, 32'h5000, 32'h6000, mk_ctl(3, 2, 1, 0, 0, 0, 0, 0, 0, 0), 0);
      chk(acc_n == 1, "R10", "requests", acc_n, 1);
      chk(err_flag, "R10", "err flag", err_flag, 1);
      chk(!busy, "R10", "busy", busy, 0);
      chk(done_n == 0, "R10", "done pulses", done_n, 0);
      repeat (3) @(negedge clk);
      chk(err_flag, "R10", "err sticky", err_flag, 1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
      chk(!err_flag, "R10", "err cleared", err_flag, 0);
   endtask

   task automatic t_retry();
      run('0, 32'h7000, 32'h8000, mk_ctl(1, 2, 1, 0, 0, 0, 0, 1, 0, 0), 1);
      chk(acc_n == 3, "R9", "requests", acc_n, 3);
      chk_req(1, 1, 32'h8000, 1, 0, "R9");
      chk_req(2, 1, 32'h8000, 1, 0, "R9");
      chk(!err_flag, "R9", "err flag", err_flag, 0);
      chk(done_n == 1, "R9", "done pulses", done_n, 1);
   endtask

   task automatic t_chain();
      dmem[0] = 32'h0; dmem[1] = 32'h9000; dmem[2] = 32'hA000;
      dmem[3] = mk_ctl(1, 2, 2, 0, 0, 0, 0, 0, 1, 1);
      run(32'h100, 32'h0, 32'hB000, mk_ctl(1, 2, 2, 0, 0, 1, 0, 0, 1, 0), -1);
      chk(acc_n == 7, "R11", "requests", acc_n, 7);
      chk_req(0, 1, 32'hB000, 2, 32'h0, "R8");
      for (int i = 0; i < 4; i++) chk_req(1 + i, 0, 32'h100 + 4 * i, 1, 0, "R11");
      chk_req(5, 0, 32'h9000, 2, 0, "R11");
      chk_req(6, 1, 32'hA000, 2, 0, "R11");
      chk(irq_n == 1, "R12", "irq pulses", irq_n, 1);
      chk(done_n == 1, "R11", "done pulses", done_n, 1);
   endtask

   task automatic t_reserved();
      run('0, 32'h1000, 32'h2000, mk_ctl(2, 3, 4, 0, 0, 0, 0, 0, 0, 0), -1);
      chk(acc_n == 0, "R4", "requests", acc_n, 0);
      chk(err_flag, "R4", "err flag", err_flag, 1);
      chk(done_n == 0, "R4", "done pulses", done_n, 0);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_count();
      t_copy_inc();
      t_fill();
      t_src_fix();
      t_err_halt();
      t_retry();
      t_chain();
      t_reserved();
      finished = 1'b1;
   end

   initial begin
      for (int k = 0; k < 100000 && !finished; k++) @(negedge clk);
      if (!finished) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual hung expected finished");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule